// File: doc/BRIEF.md
# Paired-Access Operand Register File

A bank of sixteen 16-bit operand registers with two read ports and two write paths. Every port carries a width-select bit. In narrow mode a port moves one 16-bit register. In wide mode it moves a 32-bit value held in an even/odd register pair. A wide access names the pair by its even register: the odd register holds the upper half and the even register holds the lower half.

One write path is general: it may target any register. The other write path carries multiply-type results. It may target only the registers flagged in a destination mask parameter, and a wide multiply write is legal only when both halves of the pair are flagged. Illegal accesses raise an error flag in the same cycle and change no register. Reads are combinational and see a write that is issued in the same cycle, so a result can be consumed without waiting for the register update.

Top module: `pair_regfile`

## Requirements
- R1: After the active-low asynchronous reset, every register reads as zero.
- R2: A narrow write with the general path loads `wr_data_i[15:0]` into register `wr_idx_i` at the clock edge. No other register changes.
- R3: A wide write to even index n loads `data[31:16]` into register n+1 and `data[15:0]` into register n at the same edge.
- R4: A wide read of even index n returns {register n+1, register n} on bits [31:16] and [15:0]. A narrow read returns the register on bits [15:0] with bits [31:16] at zero.
- R5: A wide access with an odd index is illegal. On a read port it raises that port's error flag and returns zero data. On a write path it raises that path's error flag and the write is blocked.
- R6: A multiply-path write is accepted only if every register it targets has its bit set in `MUL_DEST_MASK` (bit i stands for register i). Any other multiply-path write is dropped and raises `mw_err_o` in the same cycle. Any register may still be read.
- R7: A read in the same cycle as an accepted write to an overlapping register returns the newly written data. This holds for both widths and for partial overlap of a pair.
- R8: If both write paths target the same register in one cycle, the multiply-path value is stored. Writes to different registers both take effect.
- R9: The two read ports are independent: each returns its own index and width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ra_idx_i | input | 4 | Read port A register index |
| ra_wide_i | input | 1 | Read port A: 1 = 32-bit pair, 0 = 16-bit |
| ra_data_o | output | 32 | Read port A data |
| ra_err_o | output | 1 | Read port A illegal access |
| rb_idx_i | input | 4 | Read port B register index |
| rb_wide_i | input | 1 | Read port B: 1 = 32-bit pair, 0 = 16-bit |
| rb_data_o | output | 32 | Read port B data |
| rb_err_o | output | 1 | Read port B illegal access |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write index |
| wr_wide_i | input | 1 | General write width select |
| wr_data_i | input | 32 | General write data (narrow uses [15:0]) |
| wr_err_o | output | 1 | General write rejected |
| mw_en_i | input | 1 | Multiply-path write enable |
| mw_idx_i | input | 4 | Multiply-path write index |
| mw_wide_i | input | 1 | Multiply-path write width select |
| mw_data_i | input | 32 | Multiply-path write data |
| mw_err_o | output | 1 | Multiply-path write rejected |

## Verification
The bench builds the block with sixteen 16-bit registers and overrides `MUL_DEST_MASK` to 16'h0F34, so that registers 2, 4, 5 and 8 to 11 are the legal multiply destinations. This scattered mask makes pair 2 legal for a narrow multiply write to register 2 but illegal as a wide pair, because register 3 is not flagged. It also makes register 0 illegal outright. Both paths of the destination check are exercised that way. Same-cycle collisions and bypass reads are then driven against legal and illegal multiply targets alike.

// File: rtl/pair_rf_pkg.sv
package pair_rf_pkg;
  // wide access requires an even index
  function automatic logic odd_wide(input logic wide, input logic lsb);
    return wide & lsb;
  endfunction
endpackage

// File: rtl/pair_rf_wdec.sv
module pair_rf_wdec #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 16,
  parameter logic [NUM_REGS-1:0] DEST_MASK = '1,
  localparam int unsigned IDX_W  = $clog2(NUM_REGS),
  localparam int unsigned WORD_W = 2 * DATA_W
) (
  input  logic                             en_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic                             wide_i,
  input  logic [WORD_W-1:0]                data_i,
  output logic [NUM_REGS-1:0]              we_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  wd_o,
  output logic                             err_o
);
  import pair_rf_pkg::*;

  logic [IDX_W-1:0] hi_idx;
  logic             dest_ok;
  logic             bad;

  always_comb begin
    hi_idx  = idx_i | IDX_W'(1);
    dest_ok = DEST_MASK[idx_i] & (~wide_i | DEST_MASK[hi_idx]);
    bad     = odd_wide(wide_i, idx_i[0]) | ~dest_ok;
    err_o   = en_i & bad;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [IDX_W-1:0] SELF = IDX_W'(i);
    localparam bit               ODD  = (i % 2) == 1;
    assign we_o[i] = en_i & ~bad & ((idx_i == SELF) | (wide_i & (hi_idx == SELF)));
    if (ODD) begin : g_odd
      assign wd_o[i] = wide_i ? data_i[WORD_W-1:DATA_W] : data_i[DATA_W-1:0];
    end else begin : g_even
      assign wd_o[i] = data_i[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/pair_rf_rd.sv
module pair_rf_rd #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_REGS),
  localparam int unsigned WORD_W = 2 * DATA_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic                            wide_i,
  output logic [WORD_W-1:0]               data_o,
  output logic                            err_o
);
  import pair_rf_pkg::*;

  logic [IDX_W-1:0] hi_idx;

  always_comb begin
    hi_idx = idx_i | IDX_W'(1);
    err_o  = odd_wide(wide_i, idx_i[0]);
    if (err_o)       data_o = '0;
    else if (wide_i) data_o = {regs_i[hi_idx], regs_i[idx_i]};
    else             data_o = {{DATA_W{1'b0}}, regs_i[idx_i]};
  end

  always_comb begin
    if (err_o) assert_rd_err_zero_R5: assert (data_o == '0);
  end
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 16,
  parameter logic [NUM_REGS-1:0] MUL_DEST_MASK = 16'h00FF,
  localparam int unsigned IDX_W  = $clog2(NUM_REGS),
  localparam int unsigned WORD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic              ra_wide_i,
  output logic [WORD_W-1:0] ra_data_o,
  output logic              ra_err_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  input  logic              rb_wide_i,
  output logic [WORD_W-1:0] rb_data_o,
  output logic              rb_err_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_wide_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_err_o,
  input  logic              mw_en_i,
  input  logic [IDX_W-1:0]  mw_idx_i,
  input  logic              mw_wide_i,
  input  logic [WORD_W-1:0] mw_data_i,
  output logic              mw_err_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q, regs_nxt, gw_wd, mw_wd;
  logic [NUM_REGS-1:0]             gw_we, mw_we;

  pair_rf_wdec #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DEST_MASK('1)) u_gen_dec (
    .en_i(wr_en_i), .idx_i(wr_idx_i), .wide_i(wr_wide_i), .data_i(wr_data_i),
    .we_o(gw_we), .wd_o(gw_wd), .err_o(wr_err_o)
  );

  pair_rf_wdec #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DEST_MASK(MUL_DEST_MASK)) u_mul_dec (
    .en_i(mw_en_i), .idx_i(mw_idx_i), .wide_i(mw_wide_i), .data_i(mw_data_i),
    .we_o(mw_we), .wd_o(mw_wd), .err_o(mw_err_o)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    // multiply path has priority on collision
    always_comb begin
      if (mw_we[i])      regs_nxt[i] = mw_wd[i];
      else if (gw_we[i]) regs_nxt[i] = gw_wd[i];
      else               regs_nxt[i] = regs_q[i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= '0;
      else         regs_q[i] <= regs_nxt[i];
    end
  end

  // reads tap the next-state vector: write-through bypass
  pair_rf_rd #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
    .regs_i(regs_nxt), .idx_i(ra_idx_i), .wide_i(ra_wide_i),
    .data_o(ra_data_o), .err_o(ra_err_o)
  );

  pair_rf_rd #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
    .regs_i(regs_nxt), .idx_i(rb_idx_i), .wide_i(rb_wide_i),
    .data_o(rb_data_o), .err_o(rb_err_o)
  );

  assert_narrow_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_wide_i && !mw_en_i) |=>
      regs_q[$past(wr_idx_i)] == $past(wr_data_i[DATA_W-1:0]));

  assert_wide_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_wide_i && !wr_idx_i[0] && !mw_en_i) |=>
      (regs_q[$past(wr_idx_i) | IDX_W'(1)] == $past(wr_data_i[WORD_W-1:DATA_W]) &&
       regs_q[$past(wr_idx_i)] == $past(wr_data_i[DATA_W-1:0])));

  assert_odd_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_wide_i && wr_idx_i[0] && !mw_en_i) |=> $stable(regs_q));

  assert_odd_read_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_wide_i && ra_idx_i[0]) |-> (ra_err_o && ra_data_o == '0));

  assert_mul_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_err_o && !wr_en_i) |=> $stable(regs_q));

  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_wide_i && !mw_en_i && !ra_wide_i && ra_idx_i == wr_idx_i) |->
      ra_data_o == {{DATA_W{1'b0}}, wr_data_i[DATA_W-1:0]});

  assert_mul_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mw_en_i && !mw_err_o && !wr_wide_i && !mw_wide_i && wr_idx_i == mw_idx_i) |=>
      regs_q[$past(mw_idx_i)] == $past(mw_data_i[DATA_W-1:0]));
endmodule

// File: tb/pair_regfile_test.sv
module pair_regfile_test;
  localparam logic [15:0] MASK = 16'h0F34;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0, mw_idx = '0;
  logic        ra_wide = 1'b0, rb_wide = 1'b0, wr_en = 1'b0, wr_wide = 1'b0;
  logic        mw_en = 1'b0, mw_wide = 1'b0;
  logic [31:0] wr_data = '0, mw_data = '0;
  logic [31:0] ra_data, rb_data;
  logic        ra_err, rb_err, wr_err, mw_err;

  always #5 clk = ~clk;

  pair_regfile #(.NUM_REGS(16), .DATA_W(16), .MUL_DEST_MASK(MASK)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ra_idx_i(ra_idx), .ra_wide_i(ra_wide), .ra_data_o(ra_data), .ra_err_o(ra_err),
    .rb_idx_i(rb_idx), .rb_wide_i(rb_wide), .rb_data_o(rb_data), .rb_err_o(rb_err),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_wide_i(wr_wide), .wr_data_i(wr_data), .wr_err_o(wr_err),
    .mw_en_i(mw_en), .mw_idx_i(mw_idx), .mw_wide_i(mw_wide), .mw_data_i(mw_data), .mw_err_o(mw_err)
  );

  typedef struct {
    string       req;
    logic [31:0] a, b;
    logic [3:0]  errs; // {ra, rb, wr, mw}
  } item_t;

  item_t       q[$];
  logic [15:0] model [16];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] rd_model(input logic [15:0] m [16], input logic [3:0] idx, input logic w);
    if (w && idx[0]) return '0;
    if (w) return {m[idx | 4'd1], m[idx]};
    return {16'h0, m[idx]};
  endfunction

  task automatic step(input string req,
                      input logic we, input logic [3:0] wi, input logic ww, input logic [31:0] wd,
                      input logic me, input logic [3:0] mi, input logic mwd, input logic [31:0] md,
                      input logic [3:0] ai, input logic aw, input logic [3:0] bi, input logic bw);
    logic [15:0] nxt [16];
    logic        werr, merr;
    item_t       it;
    @(negedge clk);
    #1;
    wr_en = we; wr_idx = wi; wr_wide = ww; wr_data = wd;
    mw_en = me; mw_idx = mi; mw_wide = mwd; mw_data = md;
    ra_idx = ai; ra_wide = aw; rb_idx = bi; rb_wide = bw;
    nxt  = model;
    werr = we && ww && wi[0];
    merr = me && ((mwd && mi[0]) || !MASK[mi] || (mwd && !MASK[mi | 4'd1]));
    if (we && !werr) begin
      nxt[wi] = wd[15:0];
      if (ww) nxt[wi | 4'd1] = wd[31:16];
    end
    if (me && !merr) begin
      nxt[mi] = md[15:0];
      if (mwd) nxt[mi | 4'd1] = md[31:16];
    end
    it.req  = req;
    it.a    = rd_model(nxt, ai, aw);
    it.b    = rd_model(nxt, bi, bw);
    it.errs = {aw && ai[0], bw && bi[0], werr, merr};
    q.push_back(it);
    model = nxt;
  endtask

  task automatic rd(input string req, input logic [3:0] ai, input logic aw, input logic [3:0] bi, input logic bw);
    step(req, 1'b0, 4'd0, 1'b0, 32'h0, 1'b0, 4'd0, 1'b0, 32'h0, ai, aw, bi, bw);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: compares the design against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (ra_data !== e.a || rb_data !== e.b || {ra_err, rb_err, wr_err, mw_err} !== e.errs) begin
          errors++;
          $display("FAIL %s: actual a=%h b=%h err=%b expected a=%h b=%h err=%b",
                   e.req, ra_data, rb_data, {ra_err, rb_err, wr_err, mw_err}, e.a, e.b, e.errs);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state, all pairs and singles
    for (int i = 0; i < 16; i += 2) rd("R1", 4'(i), 1'b1, 4'(i + 1), 1'b0);

    // R2: narrow writes everywhere, read back next cycle
    for (int i = 0; i < 16; i++)
      step("R2", 1'b1, 4'(i), 1'b0, {16'hDEAD, 16'(16'hA000 + i * 16'h0111)},
           1'b0, 4'd0, 1'b0, 32'h0, 4'd0, 1'b0, 4'd15, 1'b0);
    for (int i = 0; i < 16; i++) rd("R2", 4'(i), 1'b0, 4'(15 - i), 1'b0);

    // R3, R4: wide writes then wide and narrow reads
    step("R3", 1'b1, 4'd6, 1'b1, 32'h1234_5678, 1'b0, 4'd0, 1'b0, 32'h0, 4'd0, 1'b0, 4'd1, 1'b0);
    rd("R4", 4'd6, 1'b1, 4'd7, 1'b0);
    rd("R4", 4'd6, 1'b0, 4'd8, 1'b1);
    step("R3", 1'b1, 4'd14, 1'b1, 32'hCAFE_F00D, 1'b0, 4'd0, 1'b0, 32'h0, 4'd0, 1'b0, 4'd0, 1'b0);
    rd("R4", 4'd14, 1'b1, 4'd15, 1'b0);

    // R5: odd-index wide accesses
    step("R5", 1'b1, 4'd5, 1'b1, 32'hFFFF_FFFF, 1'b0, 4'd0, 1'b0, 32'h0, 4'd5, 1'b1, 4'd4, 1'b1);
    rd("R5", 4'd4, 1'b1, 4'd6, 1'b1);
    rd("R5", 4'd15, 1'b1, 4'd3, 1'b1);

    // R6: multiply destinations, mask 0F34 -> r2,r4,r5,r8..r11 legal
    step("R6", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd2, 1'b0, 32'h0000_1111, 4'd2, 1'b0, 4'd3, 1'b0);
    step("R6", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd3, 1'b0, 32'h0000_2222, 4'd2, 1'b1, 4'd3, 1'b0);
    step("R6", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd2, 1'b1, 32'h3333_4444, 4'd2, 1'b1, 4'd0, 1'b0);
    step("R6", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd4, 1'b1, 32'h5555_6666, 4'd4, 1'b1, 4'd0, 1'b0);
    step("R6", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd0, 1'b0, 32'h0000_7777, 4'd0, 1'b0, 4'd12, 1'b1);
    step("R6", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd10, 1'b1, 32'h8888_9999, 4'd10, 1'b1, 4'd12, 1'b1);
    step("R6", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd9, 1'b1, 32'hAAAA_BBBB, 4'd8, 1'b1, 4'd9, 1'b0);
    rd("R6", 4'd0, 1'b0, 4'd3, 1'b0);

    // R7: same-cycle bypass, both widths and partial overlap
    step("R7", 1'b1, 4'd12, 1'b0, 32'h0000_ABCD, 1'b0, 4'd0, 1'b0, 32'h0, 4'd12, 1'b0, 4'd12, 1'b1);
    step("R7", 1'b1, 4'd0, 1'b1, 32'h0BAD_BEEF, 1'b0, 4'd0, 1'b0, 32'h0, 4'd1, 1'b0, 4'd0, 1'b1);
    step("R7", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd8, 1'b1, 32'h1357_2468, 4'd9, 1'b0, 4'd8, 1'b1);
    step("R7", 1'b0, 4'd0, 1'b0, 32'h0, 1'b1, 4'd11, 1'b0, 32'h0000_4321, 4'd10, 1'b1, 4'd11, 1'b0);

    // R8: collisions between write paths
    step("R8", 1'b1, 4'd4, 1'b0, 32'h0000_AAAA, 1'b1, 4'd4, 1'b0, 32'h0000_BBBB, 4'd4, 1'b0, 4'd5, 1'b0);
    rd("R8", 4'd4, 1'b0, 4'd4, 1'b1);
    step("R8", 1'b1, 4'd8, 1'b1, 32'h1111_2222, 1'b1, 4'd9, 1'b0, 32'h0000_3333, 4'd8, 1'b1, 4'd0, 1'b0);
    step("R8", 1'b1, 4'd13, 1'b0, 32'h0000_5A5A, 1'b1, 4'd10, 1'b1, 32'h6B6B_7C7C, 4'd13, 1'b0, 4'd10, 1'b1);
    step("R8", 1'b1, 4'd3, 1'b0, 32'h0000_0F0F, 1'b1, 4'd3, 1'b0, 32'h0000_F0F0, 4'd3, 1'b0, 4'd2, 1'b1);

    // R9: independent read ports over the whole file
    for (int i = 0; i < 16; i++) rd("R9", 4'(i), 1'b0, 4'((i * 2) % 16), 1'b1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule